// File: doc/BRIEF.md
# Bit-serial adder with JK-style carry

This block adds two unsigned operands of `W` bits by handling one bit pair per clock, least significant bit first. A start strobe loads both operands in parallel into two shift registers. The operand registers then shift right, so their bit 0 is the current bit pair. Each new sum bit enters the first operand's register at its most significant end. After `W` shifts, that register holds the complete sum.

The carry between bit positions lives in a single flip-flop with JK-style control. It is set when both current bits are 1 and cleared when both are 0. When exactly one of the bits is 1, it keeps its value. Each sum bit is the three-way exclusive OR of the two current bits and the stored carry. A result is flagged by a one-cycle done pulse. The sum and the final carry then stay on the outputs until the next accepted start. This saves area compared with a parallel adder, at the cost of `W` cycles per addition.

Top module: `bitser_adder`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy`, `done`, `sum_out` and `carry_out` are all 0.
- R2: A `start` sampled high while `busy` is low loads `a_in` and `b_in`, clears the carry, and raises `busy` at the same clock edge.
- R3: After an accepted start, `busy` stays high for exactly `W` clock cycles. `done` is high for exactly one cycle, the cycle in which `busy` has just fallen. `done` and `busy` are never high together.
- R4: While `done` is high, `sum_out` equals `(a_in + b_in) mod 2^W` for the operands loaded at the accepted start.
- R5: While `done` is high, `carry_out` equals bit `W` of the full sum `a_in + b_in`.
- R6: In every shifting cycle the carry is updated as follows. If both current operand bits are 1, the carry becomes 1. If both are 0, it becomes 0. If exactly one is 1, it is unchanged.
- R7: A `start` sampled while `busy` is high is ignored. The running addition keeps its operands and its cycle count, and reports only its own result.
- R8: While `busy` is low and no start is accepted, `sum_out` and `carry_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an addition when idle |
| a_in | input | W | First operand, loaded at start |
| b_in | input | W | Second operand, loaded at start |
| busy | output | 1 | Addition in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| sum_out | output | W | Sum (low W bits), valid from done until next start |
| carry_out | output | 1 | Carry out of the top bit, valid with sum_out |

## Verification
The assertions check these properties on every cycle:
- the carry update rule from the current bit pair;
- the carry clear and `busy` rise on an accepted start;
- the exact `W`-cycle length of `busy`, counted in the checker;
- the `done` pulse placement;
- the holding of the outputs while idle.

Only the bench scenarios can show that the arithmetic is right. These include carry chains that run across the full width, a carry out of the top bit alone, patterns that never generate a carry, and a start issued during a running addition that must leave the result unchanged.

// File: rtl/bitser_adder_pkg.sv
package bitser_adder_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_t;
endpackage

// File: rtl/bitser_shreg.sv
module bitser_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] par_in,
  input  logic         ser_in,
  output logic [W-1:0] q
);
  // right shift: bit 0 leaves, serial bit enters at the top
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= par_in;
    else if (shift) q <= {ser_in, q[W-1:1]};
  end
endmodule

// File: rtl/bitser_jk_carry.sv
module bitser_jk_carry (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic j,
  input  logic k,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= 1'b0;
    else if (en) begin
      case ({j, k})
        2'b10:   q <= 1'b1;
        2'b01:   q <= 1'b0;
        2'b11:   q <= ~q;
        default: q <= q;
      endcase
    end
  end
endmodule

// File: rtl/bitser_seq.sv
module bitser_seq
  import bitser_adder_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic shift,
  output logic busy,
  output logic done
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  seq_state_t       state;
  logic [CW-1:0]    cnt;

  assign load  = start && (state == ST_IDLE);
  assign shift = (state == ST_RUN);
  assign busy  = (state == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_RUN;
            cnt   <= '0;
          end
        end
        ST_RUN: begin
          if (cnt == LAST) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bitser_adder.sv
module bitser_adder #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] sum_out,
  output logic         carry_out
);
  logic         load, shift;
  logic [W-1:0] a_q, b_q;
  logic         a_lsb, b_lsb, cy, sum_bit;

  bitser_seq #(.W(W)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .load(load), .shift(shift), .busy(busy), .done(done)
  );

  assign a_lsb   = a_q[0];
  assign b_lsb   = b_q[0];
  assign sum_bit = a_lsb ^ b_lsb ^ cy;

  // operand A register doubles as the result register
  bitser_shreg #(.W(W)) u_areg (
    .clk(clk), .rst(rst), .load(load), .shift(shift),
    .par_in(a_in), .ser_in(sum_bit), .q(a_q)
  );

  bitser_shreg #(.W(W)) u_breg (
    .clk(clk), .rst(rst), .load(load), .shift(shift),
    .par_in(b_in), .ser_in(1'b0), .q(b_q)
  );

  bitser_jk_carry u_cy (
    .clk(clk), .rst(rst), .clr(load), .en(shift),
    .j(a_lsb & b_lsb), .k(~(a_lsb | b_lsb)), .q(cy)
  );

  assign sum_out   = a_q;
  assign carry_out = cy;
endmodule

// File: rtl/bitser_adder_chk.sv
module bitser_adder_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] sum_out,
  input logic         carry_out,
  input logic         x,
  input logic         y
);
  localparam int NW = $clog2(W + 1);
  logic [NW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst)                 run_cnt <= '0;
    else if (start && !busy) run_cnt <= '0;
    else if (busy)           run_cnt <= run_cnt + 1'b1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!busy && !done && !carry_out && sum_out == '0));
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy);
  // R2
  start_clr_chk: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> !carry_out);
  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst) !(done && busy));
  // R3
  done_at_end_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);
  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R3
  run_len_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> (run_cnt == NW'(W)));
  // R6
  cy_set_chk: assert property (@(posedge clk) disable iff (rst) (busy && x && y) |=> carry_out);
  // R6
  cy_clr_chk: assert property (@(posedge clk) disable iff (rst) (busy && !x && !y) |=> !carry_out);
  // R6
  cy_hold_chk: assert property (@(posedge clk) disable iff (rst) (busy && (x ^ y)) |=> (carry_out == $past(carry_out)));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst) (!busy && !start) |=> ($stable(sum_out) && $stable(carry_out)));
endmodule

bind bitser_adder bitser_adder_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .sum_out(sum_out), .carry_out(carry_out), .x(a_lsb), .y(b_lsb)
);

// File: tb/test_bitser_adder.sv
module test_bitser_adder;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic         busy, done, carry_out;
  logic [W-1:0] sum_out;

  int checks = 0;
  int fails  = 0;
  int busy_cycles = 0;
  bit finished = 0;
  logic [W:0] exp_q[$];
  logic [W:0] last_res;

  always #4 clk = ~clk;

  bitser_adder #(.W(W)) i_bitser_adder (
    .clk(clk), .rst(rst), .start(start), .a_in(a_in), .b_in(b_in),
    .busy(busy), .done(done), .sum_out(sum_out), .carry_out(carry_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // driver: waits for idle, issues start, pushes the expected result
  task automatic drive_add(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] full;
    while (busy) @(negedge clk);
    full = {1'b0, a} + {1'b0, b};
    exp_q.push_back(full);
    a_in  = a;
    b_in  = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", 32'(busy), 32'd1);
    check("R2 carry cleared", 32'(carry_out), 32'd0);
  endtask

  task automatic wait_idle();
    while (busy || exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: samples away from the rising edge
  always @(negedge clk) begin
    if (!rst) begin
      if (busy) busy_cycles++;
      if (done) begin
        logic [W:0] e;
        check("R3 busy length", 32'(busy_cycles), 32'(W));
        check("R3 done without busy", 32'(busy), 32'd0);
        busy_cycles = 0;
        if (exp_q.size() == 0) begin
          check("R3 unexpected done", 32'd1, 32'd0);
        end else begin
          e = exp_q.pop_front();
          check("R4 sum", 32'(sum_out), 32'(e[W-1:0]));
          check("R5 carry", 32'(carry_out), 32'(e[W]));
          last_res = e;
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state during reset
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 done", 32'(done), 32'd0);
    check("R1 sum", 32'(sum_out), 32'd0);
    check("R1 carry", 32'(carry_out), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle after reset", 32'({busy, done, carry_out}), 32'd0);

    drive_add(8'h12, 8'h34);
    drive_add(8'hFF, 8'h01);   // R6 set then hold across the chain
    drive_add(8'h80, 8'h80);   // R5 carry out of the top bit only
    drive_add(8'hAA, 8'h55);   // R6 hold with carry at 0, no carry out
    drive_add(8'hFF, 8'hFF);   // R6 set on every bit
    drive_add(8'h00, 8'h00);
    drive_add(8'h7F, 8'h01);   // R6 clear after a chain of holds
    wait_idle();

    // R8: outputs hold while idle
    repeat (5) @(negedge clk);
    check("R8 sum held", 32'(sum_out), 32'(last_res[W-1:0]));
    check("R8 carry held", 32'(carry_out), 32'(last_res[W]));

    // R7: start during busy is ignored
    drive_add(8'hC3, 8'h5A);
    repeat (2) @(negedge clk);
    a_in  = 8'h01;
    b_in  = 8'h01;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R7 busy kept", 32'(busy), 32'd1);
    wait_idle();
    check("R7 no extra result", 32'(exp_q.size()), 32'd0);
    check("R7 sum from first operands", 32'(sum_out), 32'h1D);
    check("R7 carry from first operands", 32'(carry_out), 32'd1);

    // back-to-back: start in the cycle right after done
    drive_add(8'h0F, 8'hF1);
    while (!done) @(negedge clk);
    drive_add(8'h33, 8'h44);
    wait_idle();

    finish_run();
  end
endmodule